// File: doc/BRIEF.md
# Parallel Flash Bus Front-End

This block is a clocked model of the control side of a byte-wide parallel flash device. The active-low chip-enable, output-enable and write-enable strobes and the active-low device reset come in asynchronously. Each passes through a two-stage synchroniser before it reaches any logic. From the synchronised strobes the block decodes read, command write, standby, output disable and reset. It drives an 8-bit read bus together with a separate enable for a tri-state driver outside the block.

A small internal state machine tracks the operating mode. The modes are array read, identifier readout, program armed and busy. A ready output goes low while a program or erase runs, and also during the recovery window after a device reset. The storage is a register array with a parameterised number of bytes per sector. It spans all 32 sectors selected by address bits 20..16, so a test can reach every sector boundary cheaply. The upper address bits are also brought out as a sector number.

Top module: `flash_bus_frontend`

## Requirements
- R1: After system reset every stored byte reads 0xFF and the mode is array read. A read cycle has chip-enable low, output-enable low and write-enable high. During a read cycle `dout_en` is 1 and `dout` is the byte at sector `addr[20:16]`, offset `addr[log2(BPS)-1:0]`.
- R2: A write cycle has chip-enable low, write-enable low and output-enable high. It ends when write-enable or chip-enable rises. At that point the address and data are latched as a command. Commands alone never change a stored byte.
- R3: While chip-enable is high, or output-enable is high, `dout_en` is 0, whatever the other strobes are.
- R4: While the device reset is low, `dout_en` is 0, write cycles are ignored, any operation is abandoned, and the mode returns to array read.
- R5: Command 0x90 selects identifier mode and 0xF0 selects array read. Any other value that is not a program or erase opcode leaves the mode unchanged.
- R6: In identifier mode a read with `addr[6]`=0 and `addr[1]`=0 returns 0x01 when `addr[0]`=0 and 0xAD when `addr[0]`=1. Any other address returns 0x00.
- R7: Command 0x40 arms a program. The next write stores its data at its address. `ready` is low for PROG_CYC cycles, and the new byte becomes readable when `ready` returns high.
- R8: Command 0x20 erases the addressed sector: every byte in it becomes 0xFF when the operation completes. Other sectors keep their bytes. `ready` is low for ERASE_CYC cycles.
- R9: While busy, a read returns a status byte. Bit 7 is the complement of bit 7 of the value being stored (0xFF for an erase), and bits 6..0 are 0. Write cycles during busy are ignored.
- R10: A device reset during busy leaves the target byte(s) unchanged. `ready` stays low for RECOV_BUSY cycles from the reset being seen. A reset while idle holds `ready` low for only RECOV_IDLE cycles.
- R11: `sector` always equals `addr[20:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert |
| dev_rst_n | input | 1 | Device reset strobe, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW (21) | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Enable for the external tri-state driver |
| ready | output | 1 | 1 = ready, 0 = busy or recovering |
| sector | output | AW-16 (5) | Sector number of `addr` |

## Verification
Two events can coincide: a device reset and an operation that is still busy. The bench provokes this by starting a program and pulsing reset a few cycles later. It then judges three things. `ready` must still be low after the unaborted program would have ended. `ready` must rise only after the longer recovery window. The target byte must still read 0xFF. The bench also runs an idle reset and checks that `ready` comes back within the short window.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  typedef enum logic [1:0] {M_ARRAY, M_IDENT, M_ARM, M_BUSY} fe_mode_t;

  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_ARRAY  = 8'hF0;
  localparam logic [7:0] OP_PROG   = 8'h40;
  localparam logic [7:0] OP_ERASE  = 8'h20;
  localparam logic [7:0] ID_MAKER  = 8'h01;
  localparam logic [7:0] ID_DEVICE = 8'hAD;
endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end
endmodule

// File: rtl/fe_array.sv
module fe_array #(
  parameter int SECW = 5,
  parameter int OFFW = 2,
  localparam int IW    = SECW + OFFW,
  localparam int DEPTH = 1 << IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_go,
  input  logic          erase_go,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] ridx,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [DEPTH];
  logic [7:0] mem_d [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_cell
    localparam logic [IW-1:0] ME = IW'(e);
    always_comb begin
      mem_d[e] = mem_q[e];
      if (erase_go && (ME[IW-1:OFFW] == widx[IW-1:OFFW]))
        mem_d[e] = 8'hFF;
      else if (prog_go && (ME == widx))
        mem_d[e] = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[e] <= 8'hFF;
      else if (prog_go || erase_go) mem_q[e] <= mem_d[e];
    end
  end

  assign rdata = mem_q[ridx];
endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
  import flash_fe_pkg::*;
#(
  parameter int IW         = 7,
  parameter int PROG_CYC   = 40,
  parameter int ERASE_CYC  = 60,
  parameter int RECOV_BUSY = 50,
  parameter int RECOV_IDLE = 6,
  localparam int OPMAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
  localparam int RCMAX = (RECOV_BUSY > RECOV_IDLE) ? RECOV_BUSY : RECOV_IDLE,
  localparam int CW    = $clog2(OPMAX + 1),
  localparam int RW    = $clog2(RCMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_s,
  input  logic          wr_end,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  output fe_mode_t      mode,
  output logic          busy,
  output logic          ready,
  output logic          prog_go,
  output logic          erase_go,
  output logic [IW-1:0] cmd_idx,
  output logic [7:0]    cmd_data,
  output logic [7:0]    status
);
  fe_mode_t      mode_q, mode_d;
  logic [IW-1:0] cidx_q, cidx_d;
  logic [7:0]    cdat_q, cdat_d;
  logic          cvld_q, cvld_d;
  logic          ers_q, ers_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] rcnt_q, rcnt_d;
  logic          rprev_q;
  logic          rst_fall;

  assign busy     = (mode_q == M_BUSY);
  assign rst_fall = rprev_q && !rst_s;
  assign prog_go  = busy && rst_s && (cnt_q == CW'(1)) && !ers_q;
  assign erase_go = busy && rst_s && (cnt_q == CW'(1)) && ers_q;

  always_comb begin
    mode_d = mode_q;
    cidx_d = cidx_q;
    cdat_d = cdat_q;
    ers_d  = ers_q;
    cnt_d  = cnt_q;
    cvld_d = wr_end && rst_s && !busy;
    if (cvld_d) begin
      cidx_d = wr_idx;
      cdat_d = wr_data;
    end
    if (!rst_s) begin
      mode_d = M_ARRAY;
      cnt_d  = '0;
      cvld_d = 1'b0;
    end else if (busy) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) mode_d = M_ARRAY;
    end else if (cvld_q) begin
      if (mode_q == M_ARM) begin
        mode_d = M_BUSY;
        cnt_d  = CW'(PROG_CYC);
        ers_d  = 1'b0;
      end else begin
        unique case (cdat_q)
          OP_IDENT: mode_d = M_IDENT;
          OP_ARRAY: mode_d = M_ARRAY;
          OP_PROG:  mode_d = M_ARM;
          OP_ERASE: begin
            mode_d = M_BUSY;
            cnt_d  = CW'(ERASE_CYC);
            ers_d  = 1'b1;
          end
          default: mode_d = mode_q;
        endcase
      end
    end
  end

  always_comb begin
    rcnt_d = rcnt_q;
    if (rst_fall) rcnt_d = busy ? RW'(RECOV_BUSY) : RW'(RECOV_IDLE);
    else if (rcnt_q != '0) rcnt_d = rcnt_q - RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_ARRAY;
      cidx_q  <= '0;
      cdat_q  <= '0;
      cvld_q  <= 1'b0;
      ers_q   <= 1'b0;
      cnt_q   <= '0;
      rcnt_q  <= '0;
      rprev_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      cidx_q  <= cidx_d;
      cdat_q  <= cdat_d;
      cvld_q  <= cvld_d;
      ers_q   <= ers_d;
      cnt_q   <= cnt_d;
      rcnt_q  <= rcnt_d;
      rprev_q <= rst_s;
    end
  end

  assign mode     = mode_q;
  assign ready    = !busy && (rcnt_q == '0);
  assign cmd_idx  = cidx_q;
  assign cmd_data = cdat_q;
  assign status   = {~(ers_q ? 1'b1 : cdat_q[7]), 7'b0};
endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
  import flash_fe_pkg::*;
#(
  parameter int AW         = 21,
  parameter int SEC_LSB    = 16,
  parameter int BPS        = 4,
  parameter int PROG_CYC   = 40,
  parameter int ERASE_CYC  = 60,
  parameter int RECOV_BUSY = 50,
  parameter int RECOV_IDLE = 6,
  localparam int SECW = AW - SEC_LSB,
  localparam int OFFW = $clog2(BPS),
  localparam int IW   = SECW + OFFW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dev_rst_n,
  input  logic            ce_n,
  input  logic            oe_n,
  input  logic            we_n,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      din,
  output logic [7:0]      dout,
  output logic            dout_en,
  output logic            ready,
  output logic [SECW-1:0] sector
);
  logic [3:0]    sync_q;
  logic          rst_s, ce_s, oe_s, we_s;
  logic          wr_act, wr_prev_q, wr_end;
  logic [IW-1:0] aidx, cmd_idx;
  logic [7:0]    cmd_data, status, arr_data;
  logic          busy, prog_go, erase_go;
  fe_mode_t      mode;
  logic          unused_addr;

  fe_sync #(.W(4), .RST_VAL(4'b0111)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({dev_rst_n, ce_n, oe_n, we_n}), .q(sync_q));
  assign {rst_s, ce_s, oe_s, we_s} = sync_q;

  assign wr_act = rst_s && !ce_s && !we_s && oe_s;
  assign wr_end = wr_prev_q && !wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev_q <= 1'b0;
    else        wr_prev_q <= wr_act;
  end

  assign sector      = addr[AW-1:SEC_LSB];
  assign aidx        = {addr[AW-1:SEC_LSB], addr[OFFW-1:0]};
  assign unused_addr = ^addr;

  fe_ctrl #(
    .IW(IW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .RECOV_BUSY(RECOV_BUSY), .RECOV_IDLE(RECOV_IDLE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rst_s(rst_s), .wr_end(wr_end),
    .wr_idx(aidx), .wr_data(din), .mode(mode), .busy(busy),
    .ready(ready), .prog_go(prog_go), .erase_go(erase_go),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .status(status));

  fe_array #(.SECW(SECW), .OFFW(OFFW)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
    .widx(cmd_idx), .wdata(cmd_data), .ridx(aidx), .rdata(arr_data));

  assign dout_en = rst_s && !ce_s && !oe_s && we_s;

  always_comb begin
    if (busy)
      dout = status;
    else if (mode == M_IDENT)
      dout = (addr[6] || addr[1]) ? 8'h00 : (addr[0] ? ID_DEVICE : ID_MAKER);
    else
      dout = arr_data;
  end
endmodule

// File: rtl/flash_fe_chk.sv
module flash_fe_chk
  import flash_fe_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rst_s,
  input logic       ce_s,
  input logic       oe_s,
  input logic       busy,
  input fe_mode_t   mode,
  input logic       ready,
  input logic       dout_en,
  input logic [7:0] dout
);
  // R3
  idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_s || oe_s) |-> !dout_en);
  // R4
  rst_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_s |-> !dout_en);
  // R4
  rst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_s |=> (mode == M_ARRAY));
  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready);
  // R9
  status_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dout_en) |-> (dout[6:0] == 7'b0));
endmodule

bind flash_bus_frontend flash_fe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_s(rst_s), .ce_s(ce_s), .oe_s(oe_s),
  .busy(busy), .mode(mode), .ready(ready), .dout_en(dout_en), .dout(dout));

// File: tb/test_flash_bus_frontend.sv
module test_flash_bus_frontend;
  logic        clk = 1'b0;
  logic        rst_n, dev_rst_n, ce_n, oe_n, we_n;
  logic [20:0] addr;
  logic [7:0]  din, dout;
  logic        dout_en, ready;
  logic [4:0]  sector;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flash_bus_frontend i_flash_bus_frontend (
    .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .ready(ready), .sector(sector));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [20:0] a, input logic [7:0] d, input bit ce_edge = 0);
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    cyc(4);
    if (ce_edge) begin ce_n = 1'b1; cyc(4); we_n = 1'b1; end
    else begin we_n = 1'b1; ce_n = 1'b1; end
    cyc(6);
  endtask

  task automatic rd(input logic [20:0] a, output logic [7:0] d, output logic en);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    cyc(4);
    d = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(3);
  endtask

  task automatic rd_chk(input string tag, input logic [20:0] a, input logic [7:0] exp);
    logic [7:0] d; logic en;
    rd(a, d, en);
    chk({tag, " en"}, en, 1);
    chk(tag, d, exp);
  endtask

  task automatic t_reset_state();
    chk("R1 ready", ready, 1);
    chk("R3 idle hiz", dout_en, 0);
    rd_chk("R1 erased byte", 21'h1F0003, 8'hFF);
    addr = 21'h1F0000; cyc(1);
    chk("R11 sector 31", sector, 5'd31);
    addr = 21'h0AFFFF; cyc(1);
    chk("R11 sector 10", sector, 5'd10);
  endtask

  task automatic t_hiz();
    addr = 0; ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; cyc(4);
    chk("R3 standby", dout_en, 0);
    ce_n = 1'b0; oe_n = 1'b1; cyc(4);
    chk("R3 output disable", dout_en, 0);
    ce_n = 1'b1; cyc(4);
  endtask

  task automatic t_program(input logic [20:0] a, input logic [7:0] d);
    logic [7:0] s; logic en;
    wr(a, 8'h40);
    wr(a, d);
    chk("R7 ready low", ready, 0);
    rd(a, s, en);
    chk("R9 status", s, {~d[7], 7'b0});
    cyc(50);
    chk("R7 ready back", ready, 1);
    rd_chk("R7 programmed", a, d);
  endtask

  task automatic t_ident();
    wr(21'h000000, 8'h90);
    rd_chk("R6 maker", 21'h000000, 8'h01);
    rd_chk("R6 device", 21'h000001, 8'hAD);
    rd_chk("R6 a6 set", 21'h000040, 8'h00);
    rd_chk("R6 a1 set", 21'h000002, 8'h00);
    wr(21'h000000, 8'h55);
    rd_chk("R5 unknown ignored", 21'h000001, 8'hAD);
    wr(21'h000000, 8'hF0, 1);
    rd_chk("R2 ce edge back to array", 21'h000003, 8'h5A);
    rd_chk("R2 commands leave array", 21'h000000, 8'hFF);
    wr(21'h000000, 8'h90, 1);
    rd_chk("R2 ce edge ident", 21'h000000, 8'h01);
    wr(21'h000000, 8'hF0);
  endtask

  task automatic t_erase();
    logic [7:0] s; logic en;
    wr(21'h000002, 8'h20);
    chk("R8 ready low", ready, 0);
    rd(21'h000003, s, en);
    chk("R9 erase status", s, 8'h00);
    wr(21'h000000, 8'h90);
    cyc(70);
    chk("R8 ready back", ready, 1);
    rd_chk("R8 sector0 erased", 21'h000003, 8'hFF);
    rd_chk("R8 sector1 kept", 21'h010000, 8'hC3);
    rd_chk("R9 busy write ignored", 21'h000000, 8'hFF);
  endtask

  task automatic t_rst_idle();
    logic [7:0] s; logic en;
    wr(21'h000000, 8'h90);
    dev_rst_n = 1'b0; cyc(5);
    chk("R10 idle recovery low", ready, 0);
    rd(21'h000000, s, en);
    chk("R4 hiz in reset", en, 0);
    wr(21'h000001, 8'h40);
    cyc(10);
    chk("R10 idle recovery done", ready, 1);
    dev_rst_n = 1'b1; cyc(4);
    rd_chk("R4 back to array", 21'h000000, 8'hFF);
    wr(21'h000001, 8'hA5);
    rd_chk("R4 write in reset ignored", 21'h000001, 8'hFF);
  endtask

  task automatic t_rst_busy();
    wr(21'h000002, 8'h40);
    wr(21'h000002, 8'h12);
    dev_rst_n = 1'b0; cyc(4);
    dev_rst_n = 1'b1;
    cyc(41);
    chk("R10 busy recovery low", ready, 0);
    cyc(25);
    chk("R10 busy recovery done", ready, 1);
    rd_chk("R10 aborted byte", 21'h000002, 8'hFF);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dev_rst_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    addr = '0; din = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset_state();
    t_hiz();
    t_program(21'h000003, 8'h5A);
    t_program(21'h010000, 8'hC3);
    t_ident();
    t_erase();
    t_rst_idle();
    t_rst_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule